// File: doc/BRIEF.md
# Serial ADC Output Sequencer

This block produces the serial output of a successive-approximation converter that uses a 3-wire link. The three lines are an active-low chip select, a data clock supplied by the host, and a data line that can be tri-stated. A converted word arrives on a parallel test input. When chip select goes low, the block counts falling data-clock edges through the sampling window. It then drives a single low null bit and sends the word most significant bit first. After that it sends the word again least significant bit first, without repeating bit 0, and releases the line.

The block runs on a fast system clock with a synchronous active-low reset. It samples chip select and the data clock as ordinary inputs, which are assumed to be synchronized already. Each output change follows a detected falling edge of the data clock by one system-clock cycle. The tri-state is modelled as an output-enable beside the data bit. Chip select going high disables that enable at once, with no clock edge needed. After the last replayed bit the block ignores further clocks until chip select goes high and then low again.

Top module: `sos_adc_out`

## Requirements
- R1: While reset is held and directly after it is released, `dout_oe` and `dout` are both 0.
- R2: A cycle starts only when chip select is seen high in one system clock and low in the next. If chip select is already low when reset is released, clocks give no output until chip select has gone high and then low.
- R3: In a cycle, the first falling data-clock edge leaves `dout_oe` at 0. The second falling edge sets `dout_oe` to 1 with `dout` at 0, which is the null bit.
- R4: Falling edges 3 to DATA_W+2 put word bits DATA_W-1 down to 0 on `dout`, one bit per edge.
- R5: Falling edges DATA_W+3 to 2*DATA_W+1 put word bits 1 up to DATA_W-1 on `dout`, so bit 0 is sent only once.
- R6: From falling edge 2*DATA_W+2 onward, `dout_oe` is 0 and further data-clock edges change nothing.
- R7: `dout` and `dout_oe` change only after falling data-clock edges. A rising edge leaves them unchanged.
- R8: Chip select going high makes `dout_oe` 0 in the same cycle, at any point of a transfer.
- R9: A chip-select high-then-low sequence after a finished or aborted cycle starts a complete new sequence.
- R10: The word on `result_in` is captured at the second falling edge. Changes to `result_in` after that do not alter the bits being sent.
- R11: Whenever `dout_oe` is 0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select, already synchronized |
| dclk | input | 1 | Data clock from the host, already synchronized |
| result_in | input | DATA_W | Converted word, test input |
| dout | output | 1 | Serial data bit |
| dout_oe | output | 1 | Output enable for the data line (0 means high impedance) |

## Verification
The bench builds two copies of the block side by side, one with DATA_W=4 and one with DATA_W=12, and drives both with the same chip-select and data-clock stimulus. With the 4-bit copy, all sixteen word values can be run through the complete forward, replay and idle sequence. The 12-bit copy checks the real frame length and the saturation point with chosen patterns that include all zeros and all ones. Both copies see an aborted transfer, the result input changing in the middle of a frame, rising-edge holds, and a chip select held low through reset.

// File: rtl/sos_pkg.sv
// Package: shared constants and helpers for the serial output sequencer.
// Assumes DATA_W >= 2.
package sos_pkg;

    // Number of falling edges after which the frame is finished.
    function automatic int frame_end(input int w);
        return 2 * w + 2;
    endfunction

    // Counter width needed to hold frame_end(w).
    function automatic int cnt_width(input int w);
        return $clog2(2 * w + 3);
    endfunction

endpackage

// File: rtl/sos_edge_det.sv
// Module: sos_edge_det
// Detects a falling edge on chip select and on the data clock. Both inputs
// are assumed synchronized to clk. Each detect output is high for exactly one
// clk cycle. The history registers reset low, so a line that is already low at
// reset does not register as an edge.
module sos_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic dclk,
    output logic cs_fall,
    output logic dclk_fall
);
    logic cs_q;
    logic dclk_q;

    // Keep one cycle of history for each line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q   <= 1'b0;
            dclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_n;
            dclk_q <= dclk;
        end
    end

    // A falling edge is high in the previous cycle and low in this one.
    always_comb begin
        cs_fall   = cs_q & ~cs_n;
        dclk_fall = dclk_q & ~dclk;
    end

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_fall |=> !dclk_fall); // R7

endmodule

// File: rtl/sos_phase_ctr.sv
// Module: sos_phase_ctr
// Counts falling data-clock edges inside one chip-select cycle. The count is
// cleared by a chip-select falling edge, held at 0 while chip select is high,
// and stops at the frame end until the next cycle starts.
module sos_phase_ctr #(
    parameter int DATA_W = 12,
    parameter int CNT_W  = sos_pkg::cnt_width(DATA_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             cs_fall,
    input  logic             dclk_fall,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] END_C = CNT_W'(sos_pkg::frame_end(DATA_W));

    logic armed;

    // Arm on a chip-select fall, count falling edges, stop at the frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (cs_fall) begin
            armed <= 1'b1;
            cnt   <= '0;
        end else if (cs_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (armed && dclk_fall && cnt != END_C) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> (cnt == '0 || cnt == $past(cnt) + CNT_W'(1))); // R7

    AST_CNT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == END_C) |=> (cnt == END_C || cnt == '0)); // R6

endmodule

// File: rtl/sos_bit_sel.sv
// Module: sos_bit_sel
// Captures the word at the second falling edge and picks the bit for the
// current edge count: null bit, then descending order, then ascending order
// starting at bit 1. It assumes cnt only rises one step at a time.
module sos_bit_sel #(
    parameter int DATA_W = 12,
    parameter int CNT_W  = sos_pkg::cnt_width(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              dclk_fall,
    input  logic [DATA_W-1:0] result_in,
    output logic              bit_en,
    output logic              bit_val
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int FWD_LAST = DATA_W + 2;
    localparam int REV_LAST = 2 * DATA_W + 1;

    logic [DATA_W-1:0] word;
    int                idx;

    // Capture the word on the edge that moves the count from 1 to 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (dclk_fall && cnt == CNT_W'(1)) begin
            word <= result_in;
        end
    end

    // Map the edge count to the enable and the bit index.
    always_comb begin
        idx     = 0;
        bit_en  = 1'b0;
        bit_val = 1'b0;
        if (int'(cnt) == 2) begin
            bit_en = 1'b1;
        end else if (int'(cnt) >= 3 && int'(cnt) <= FWD_LAST) begin
            bit_en  = 1'b1;
            idx     = FWD_LAST - int'(cnt);
            bit_val = word[idx[IDX_W-1:0]];
        end else if (int'(cnt) > FWD_LAST && int'(cnt) <= REV_LAST) begin
            bit_en  = 1'b1;
            idx     = int'(cnt) - FWD_LAST;
            bit_val = word[idx[IDX_W-1:0]];
        end
    end

    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > CNT_W'(2)) |-> $stable(word)); // R10

endmodule

// File: rtl/sos_adc_out.sv
// Module: sos_adc_out (top)
// Serial output sequencer for a successive-approximation converter that uses
// a 3-wire link. It assumes cs_n and dclk are synchronized to clk. The enable
// is gated directly by chip select, so releasing chip select takes effect
// without waiting for a clock edge.
module sos_adc_out #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              dclk,
    input  logic [DATA_W-1:0] result_in,
    output logic              dout,
    output logic              dout_oe
);
    localparam int CNT_W = sos_pkg::cnt_width(DATA_W);

    logic             cs_fall;
    logic             dclk_fall;
    logic [CNT_W-1:0] cnt;
    logic             bit_en;
    logic             bit_val;

    sos_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .dclk      (dclk),
        .cs_fall   (cs_fall),
        .dclk_fall (dclk_fall)
    );

    sos_phase_ctr #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .cs_fall   (cs_fall),
        .dclk_fall (dclk_fall),
        .cnt       (cnt)
    );

    sos_bit_sel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt       (cnt),
        .dclk_fall (dclk_fall),
        .result_in (result_in),
        .bit_en    (bit_en),
        .bit_val   (bit_val)
    );

    // Gate the enable with chip select and hold the data bit low when disabled.
    always_comb begin
        dout_oe = bit_en & ~cs_n;
        dout    = dout_oe & bit_val;
    end

    AST_NULL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> !dout); // R3

endmodule

// File: tb/sim_sos_adc_out.sv
// Bench: drives two copies of the block (4-bit and 12-bit) with the same
// chip-select and data-clock stimulus and checks every edge against values
// computed from the frame layout.
module sim_sos_adc_out;
    localparam int CLK_P = 10;
    localparam int WA = 4;
    localparam int WB = 12;
    localparam int NFALL = 2 * WB + 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          dclk = 1'b1;
    logic [WA-1:0] res_a = '0;
    logic [WB-1:0] res_b = '0;
    logic          dout_a, oe_a, dout_b, oe_b;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_P / 2) clk = ~clk;

    sos_adc_out #(.DATA_W(WA)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk),
        .result_in(res_a), .dout(dout_a), .dout_oe(oe_a)
    );

    sos_adc_out #(.DATA_W(WB)) u1 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk),
        .result_in(res_b), .dout(dout_b), .dout_oe(oe_b)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Expected {oe, bit} for falling edge k of a w-bit frame holding word wd.
    function automatic logic [1:0] expect_out(input int k, input int w, input logic [WB-1:0] wd);
        if (k < 2) return 2'b00;
        if (k == 2) return 2'b10;
        if (k <= w + 2) return {1'b1, wd[w + 2 - k]};
        if (k <= 2 * w + 1) return {1'b1, wd[k - w - 2]};
        return 2'b00;
    endfunction

    function automatic string req_of(input int k, input int w);
        if (k <= 2) return "R3";
        if (k <= w + 2) return "R4 R10";
        if (k <= 2 * w + 1) return "R5 R10";
        return "R6";
    endfunction

    task automatic wait_neg(input int n);
        for (int j = 0; j < n; j++) @(negedge clk);
    endtask

    task automatic chk_both(input int k, input logic [WB-1:0] wa, input logic [WB-1:0] wb, input string pre);
        logic [1:0] ea;
        logic [1:0] eb;
        ea = expect_out(k, WA, wa);
        eb = expect_out(k, WB, wb);
        chk({pre, req_of(k, WA), " oe4"}, oe_a, ea[1]);
        chk({pre, req_of(k, WA), " d4"}, dout_a, ea[0]);
        chk({pre, req_of(k, WB), " oe12"}, oe_b, eb[1]);
        chk({pre, req_of(k, WB), " d12"}, dout_b, eb[0]);
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        miscompares++;
        vectors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin : stim
        logic [WB-1:0] wa;
        logic [WB-1:0] wb;
        bit aborted;
        // R1 and R2: chip select held low through reset.
        cs_n = 1'b0;
        wait_neg(3);
        chk("R1 oe4", oe_a, 1'b0);
        chk("R1 oe12", oe_b, 1'b0);
        chk("R1 d4", dout_a, 1'b0);
        rst_n = 1'b1;
        wait_neg(2);
        chk("R1 oe4 after", oe_a, 1'b0);
        chk("R1 oe12 after", oe_b, 1'b0);
        for (int k = 1; k <= 5; k++) begin
            dclk = 1'b0; wait_neg(2);
            chk("R2 oe4 no start", oe_a, 1'b0);
            chk("R2 oe12 no start", oe_b, 1'b0);
            dclk = 1'b1; wait_neg(2);
        end
        cs_n = 1'b1;
        wait_neg(3);

        for (int i = 0; i < 16; i++) begin
            wa = WB'(i);
            if (i == 0) wb = '0;
            else if (i == 15) wb = '1;
            else wb = WB'(i * 1237 + 2730);
            res_a = wa[WA-1:0];
            res_b = wb;
            aborted = 1'b0;
            cs_n = 1'b0;
            wait_neg(3);
            chk("R11 oe4 before first edge", oe_a, 1'b0);
            for (int k = 1; k <= NFALL; k++) begin
                dclk = 1'b0;
                wait_neg(2);
                chk_both(k, wa, wb, (i > 0 && k == 3) ? "R9 " : "");
                if (!oe_a) chk("R11 d4 off", dout_a, 1'b0);
                if (!oe_b) chk("R11 d12 off", dout_b, 1'b0);
                if (k == 3) begin
                    // R10: disturb the input after capture.
                    res_a = ~wa[WA-1:0];
                    res_b = ~wb;
                end
                if (i == 5 && k == 8) begin
                    // R8: release chip select mid-frame; enable must drop at once.
                    cs_n = 1'b1;
                    #1;
                    chk("R8 oe4 abort", oe_a, 1'b0);
                    chk("R8 oe12 abort", oe_b, 1'b0);
                    chk("R8 R11 d12 abort", dout_b, 1'b0);
                    dclk = 1'b1;
                    aborted = 1'b1;
                    break;
                end
                dclk = 1'b1;
                wait_neg(2);
                chk_both(k, wa, wb, "R7 ");
            end
            if (!aborted) cs_n = 1'b1;
            wait_neg(3);
            chk("R8 oe4 idle", oe_a, 1'b0);
            chk("R8 oe12 idle", oe_b, 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule